// File: doc/BRIEF.md
# Read Latency Responder

This block sits on the memory side of a read bus that addresses whole cache blocks. It accepts read requests, each with a block address and a tag, and returns the full data block after a fixed, parameterised access latency. A block address maps to byte address `block address * BLOCK_BYTES`. A small backing array holds the blocks. It is loaded through a plain write port and read at the moment a request is accepted, so the data returned is the data present at acceptance.

Outstanding reads sit in a table of `DEPTH` slots. Each slot counts down once per cycle. A slot whose count has reached zero may drive the response bus for one cycle, and it is then freed. A new read to a block address that already has a pending slot takes that slot's remaining count instead of the full latency. Repeated reads of one block therefore finish back to back rather than each paying the whole delay. When every slot is busy and none is retiring, the request side is held off.

Top module: `rdlat_responder`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rsp_valid` is low and `req_ready` is high.
- R2: A read accepted at clock edge P0, with no other slot pending, drives `rsp_valid` high in exactly the cycle that follows edge P0+LATENCY, for one cycle only.
- R3: The response carries the block stored at the request's address at the acceptance edge. A write to that address after acceptance does not change it.
- R4: Each response returns the tag and block address of the request it answers on `rsp_tag` and `rsp_addr`.
- R5: A read whose block address equals a pending slot's address takes that slot's count after this cycle's decrement. If several slots match, the lowest-index match is used. The two reads then become ready in the same cycle.
- R6: A read whose address matches no pending slot waits the full LATENCY, even if other reads are pending.
- R7: At most one response is issued per cycle. Among ready slots the lowest index goes first, so reads merged into the lowest-index slots return in consecutive cycles in slot order.
- R8: `req_ready` is low while all DEPTH slots are occupied and none retires in that cycle. It is high in a cycle where a slot retires, and the waiting request then takes the freed slot.
- R9: Only bank 0 may be selected. An accepted request with nonzero `req_bank` is a protocol error.
- R10: Counts stop at zero. With no accepted request, `rsp_valid` stays low however long the block idles. A new read is placed in the lowest-index free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | ADDR_W | Block address of the read |
| req_tag | input | TAG_W | Requester tag |
| req_bank | input | BANK_W | Bank select, must be zero |
| load_en | input | 1 | Write one block into the backing array |
| load_addr | input | ADDR_W | Block address for the write |
| load_data | input | BLOCK_BYTES*8 | Block written |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_tag | output | TAG_W | Tag of the answered read |
| rsp_addr | output | ADDR_W | Block address of the answered read |
| rsp_data | output | BLOCK_BYTES*8 | Block captured at acceptance |

## Verification
The bench aims at the off-by-one spots in the countdown. It checks that the response appears neither a cycle early nor a cycle late. It also checks that merged reads land in directly consecutive cycles: a design that copied the pending count before its decrement would return the second read one cycle too late. A write placed right after a read catches a design that samples memory at completion. The full-table case checks that the stalled request is taken in the very cycle a slot retires, rather than one cycle later or into an occupied slot.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

    // Bits needed to index n items; never less than one.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rdlat_first.sv
// Lowest-index set bit finder.
module rdlat_first #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rdlat_store.sv
// Block-wide backing array: synchronous write, combinational read.
module rdlat_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/rdlat_table.sv
// Outstanding-read table: allocation, countdown, address merge, retire pick.
module rdlat_table
    import rdlat_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int TAG_W   = 8,
    parameter int DATA_W  = 64,
    parameter int DEPTH   = 16,
    parameter int LATENCY = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    localparam int IW    = idx_bits(DEPTH);
    localparam int CNT_W = idx_bits(LATENCY + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(LATENCY);

    typedef struct packed {
        logic              vld;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } tbl_t;

    tbl_t st_d, st_q;

    logic [DEPTH-1:0] vld_vec;
    logic [DEPTH-1:0] rdy_vec;
    logic [DEPTH-1:0] free_vec;
    logic [DEPTH-1:0] hit_vec;
    logic [CNT_W-1:0] dec_cnt [DEPTH];

    logic          pick_found, slot_found, hit_found;
    logic [IW-1:0] pick_idx, slot_idx, hit_idx;
    logic          accept;
    logic [CNT_W-1:0] start_cnt;

    // Per-slot status vectors and the saturating decrement.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld_vec[i] = st_q.slot[i].vld;
            rdy_vec[i] = st_q.slot[i].vld && (st_q.slot[i].cnt == '0);
            hit_vec[i] = st_q.slot[i].vld && (st_q.slot[i].addr == in_addr);
            dec_cnt[i] = (st_q.slot[i].cnt == '0) ? '0 : st_q.slot[i].cnt - 1'b1;
        end
    end

    rdlat_first #(.N(DEPTH), .IW(IW)) u_pick (
        .vec   (rdy_vec),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            free_vec[i] = !st_q.slot[i].vld || (pick_found && (pick_idx == IW'(i)));
        end
    end

    rdlat_first #(.N(DEPTH), .IW(IW)) u_slot (
        .vec   (free_vec),
        .found (slot_found),
        .idx   (slot_idx)
    );

    rdlat_first #(.N(DEPTH), .IW(IW)) u_hit (
        .vec   (hit_vec),
        .found (hit_found),
        .idx   (hit_idx)
    );

    assign in_ready  = slot_found;
    assign accept    = in_valid && slot_found;
    assign start_cnt = hit_found ? dec_cnt[hit_idx] : FULL_CNT;

    assign out_valid = pick_found;
    assign out_tag   = st_q.slot[pick_idx].tag;
    assign out_addr  = st_q.slot[pick_idx].addr;
    assign out_data  = st_q.slot[pick_idx].data;

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            st_d.slot[i].cnt = dec_cnt[i];
            if (pick_found && (pick_idx == IW'(i))) begin
                st_d.slot[i].vld = 1'b0;
            end
            if (accept && (slot_idx == IW'(i))) begin
                st_d.slot[i].vld  = 1'b1;
                st_d.slot[i].cnt  = start_cnt;
                st_d.slot[i].addr = in_addr;
                st_d.slot[i].tag  = in_tag;
                st_d.slot[i].data = in_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_vec == '0) |-> !out_valid); // R10

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(vld_vec) == DEPTH) && !out_valid) |-> !in_ready); // R8

    AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !out_valid) |=> ($countones(vld_vec) == $past($countones(vld_vec)) + 1)); // R8

    AST_RETIRE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !accept) |=> ($countones(vld_vec) + 1 == $past($countones(vld_vec)))); // R7

endmodule

// File: rtl/rdlat_responder.sv
// Top: backing array plus outstanding-read table.
module rdlat_responder #(
    parameter int ADDR_W      = 10,
    parameter int TAG_W       = 8,
    parameter int BANK_W      = 2,
    parameter int BLOCK_BYTES = 8,
    parameter int DEPTH       = 16,
    parameter int LATENCY     = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [TAG_W-1:0]         req_tag,
    input  logic [BANK_W-1:0]        req_bank,
    input  logic                     load_en,
    input  logic [ADDR_W-1:0]        load_addr,
    input  logic [BLOCK_BYTES*8-1:0] load_data,
    output logic                     rsp_valid,
    output logic [TAG_W-1:0]         rsp_tag,
    output logic [ADDR_W-1:0]        rsp_addr,
    output logic [BLOCK_BYTES*8-1:0] rsp_data
);
    localparam int DATA_W = BLOCK_BYTES * 8;

    logic [DATA_W-1:0] rd_block;

    rdlat_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_addr (req_addr),
        .rd_data (rd_block)
    );

    rdlat_table #(
        .ADDR_W  (ADDR_W),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W),
        .DEPTH   (DEPTH),
        .LATENCY (LATENCY)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_addr   (req_addr),
        .in_tag    (req_tag),
        .in_data   (rd_block),
        .out_valid (rsp_valid),
        .out_tag   (rsp_tag),
        .out_addr  (rsp_addr),
        .out_data  (rsp_data)
    );

    AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (req_bank == '0)); // R9

endmodule

// File: tb/rdlat_responder_tb_top.sv
module rdlat_responder_tb_top;
    localparam int AW  = 6;
    localparam int TW  = 8;
    localparam int BW  = 2;
    localparam int BB  = 8;
    localparam int DW  = BB * 8;
    localparam int DEP = 4;
    localparam int LAT = 12;

    // {addr, tag, data}
    localparam logic [AW+TW+DW-1:0] VECS [4] = '{
        {6'd1,  8'h11, 64'h0123_4567_89ab_cdef},
        {6'd2,  8'h22, 64'hfeed_face_cafe_beef},
        {6'd63, 8'h33, 64'h0000_0000_0000_0001},
        {6'd0,  8'h44, 64'hffff_ffff_ffff_ffff}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [TW-1:0] req_tag = '0;
    logic [BW-1:0] req_bank = '0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic          rsp_valid;
    logic [TW-1:0] rsp_tag;
    logic [AW-1:0] rsp_addr;
    logic [DW-1:0] rsp_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rdlat_responder #(
        .ADDR_W(AW), .TAG_W(TW), .BANK_W(BW), .BLOCK_BYTES(BB),
        .DEPTH(DEP), .LATENCY(LAT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_tag(req_tag), .req_bank(req_bank),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
        load_en = 1'b1; load_addr = a; load_data = d;
        tick();
        load_en = 1'b0;
    endtask

    // Present a read for one edge; returns at the following negedge.
    task automatic issue(input logic [AW-1:0] a, input logic [TW-1:0] t);
        req_valid = 1'b1; req_addr = a; req_tag = t; req_bank = '0;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        // R1: reset state
        wait_n(3);
        chk("R1", "rsp_valid in reset", DW'(rsp_valid), DW'(0));
        chk("R1", "req_ready in reset", DW'(req_ready), DW'(1));
        rst_n = 1'b1;
        tick();
        chk("R1", "rsp_valid after reset", DW'(rsp_valid), DW'(0));
        chk("R1", "req_ready after reset", DW'(req_ready), DW'(1));

        // R10: idle with nothing accepted stays quiet
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 3 * LAT; i++) begin
                tick();
                if (rsp_valid) seen = 1'b1;
            end
            chk("R10", "spurious response while idle", DW'(seen), DW'(0));
        end

        // Vector walk: R2, R4, R6, R9 (bank 0 only)
        for (int v = 0; v < 4; v++) begin
            logic [AW-1:0] va;
            logic [TW-1:0] vt;
            logic [DW-1:0] vd;
            {va, vt, vd} = VECS[v];
            load(va, vd);
            issue(va, vt);
            wait_n(LAT - 1);
            chk("R2", "early response", DW'(rsp_valid), DW'(0));
            tick();
            chk("R2", "response on time", DW'(rsp_valid), DW'(1));
            chk("R4", "rsp_tag", DW'(rsp_tag), DW'(vt));
            chk("R4", "rsp_addr", DW'(rsp_addr), DW'(va));
            chk("R6", "rsp_data", rsp_data, vd);
            tick();
            chk("R2", "single-cycle response", DW'(rsp_valid), DW'(0));
        end

        // R3: data captured at acceptance
        load(6'd5, 64'h1111_2222_3333_4444);
        issue(6'd5, 8'h50);
        load(6'd5, 64'h9999_8888_7777_6666);
        wait_n(LAT - 1);
        chk("R3", "response present", DW'(rsp_valid), DW'(1));
        chk("R3", "captured block", rsp_data, 64'h1111_2222_3333_4444);
        tick();
        issue(6'd5, 8'h51);
        wait_n(LAT);
        chk("R3", "later read sees new block", rsp_data, 64'h9999_8888_7777_6666);
        tick();

        // R5/R7: merged reads finish in consecutive cycles in slot order
        load(6'd7, 64'h7777_0000_7777_0000);
        issue(6'd7, 8'hA1);          // accepted at P0, now at N1
        wait_n(3);                   // N4
        issue(6'd7, 8'hB2);          // P4, now N5
        issue(6'd7, 8'hC3);          // P5, now N6
        wait_n(LAT - 6);             // N_LAT
        chk("R5", "no response before shared deadline", DW'(rsp_valid), DW'(0));
        tick();
        chk("R7", "first merged tag", DW'(rsp_valid ? rsp_tag : 8'h00), DW'(8'hA1));
        tick();
        chk("R5", "second merged tag", DW'(rsp_valid ? rsp_tag : 8'h00), DW'(8'hB2));
        tick();
        chk("R7", "third merged tag", DW'(rsp_valid ? rsp_tag : 8'h00), DW'(8'hC3));
        chk("R5", "merged data", rsp_data, 64'h7777_0000_7777_0000);
        tick();
        chk("R7", "merge drained", DW'(rsp_valid), DW'(0));
        tick();

        // R8: back-pressure when full, release on retire
        issue(6'd10, 8'hD0);
        issue(6'd11, 8'hD1);
        issue(6'd12, 8'hD2);
        issue(6'd13, 8'hD3);         // now N4
        chk("R8", "ready low when full", DW'(req_ready), DW'(0));
        req_valid = 1'b1; req_addr = 6'd20; req_tag = 8'h99; req_bank = '0;
        wait_n(LAT - 4);             // N_LAT
        chk("R8", "ready still low", DW'(req_ready), DW'(0));
        tick();                      // N_LAT+1
        chk("R8", "ready high on retire", DW'(req_ready), DW'(1));
        chk("R4", "first full-table tag", DW'(rsp_valid ? rsp_tag : 8'h00), DW'(8'hD0));
        tick();                      // accepted at P_LAT+1
        req_valid = 1'b0;
        chk("R6", "second full-table tag", DW'(rsp_valid ? rsp_tag : 8'h00), DW'(8'hD1));
        wait_n(2);                   // N_LAT+4
        chk("R6", "fourth full-table tag", DW'(rsp_valid ? rsp_tag : 8'h00), DW'(8'hD3));
        wait_n(LAT - 3);             // N_2LAT+1
        chk("R8", "stalled read not early", DW'(rsp_valid), DW'(0));
        tick();                      // N_2LAT+2
        chk("R8", "stalled read answered", DW'(rsp_valid ? rsp_tag : 8'h00), DW'(8'h99));
        chk("R10", "took lowest free slot, addr", DW'(rsp_addr), DW'(6'd20));
        tick();

        // R10: counts stay at zero, nothing left
        wait_n(LAT);
        chk("R10", "quiet after drain", DW'(rsp_valid), DW'(0));
        chk("R10", "ready after drain", DW'(req_ready), DW'(1));

        done = 1'b1;
        summary();
    end
endmodule